// File: doc/BRIEF.md
# Blanking-Line Noise Classifier

This block estimates how noisy the incoming luminance is by looking at one selected line during vertical blanking, where the picture content should be flat. It then assigns the signal to one of three quality classes. A downstream recursive noise filter uses that class to pick its coefficients and comparator limits. A line counter follows the line and field sync strobes. On the chosen line, the block adds up the absolute differences between neighbouring luma samples over a fixed window. It compares that sum with two programmable limits.

The class output is a registered 2-bit value. It changes only when the first line of a field starts, so the filter setting stays constant for the whole field. A control bit for tape sources turns off the adaptation and forces the middle class.

Top module: `snr_line_classifier`

## Requirements
- R1: `class_o` encodes 0 = low S/N (noisy), 1 = middle, 2 = high S/N (clean). The value 3 never appears. After reset the output is 1.
- R2: A field sync pulse resets the line count. Each line sync pulse that follows starts the next line, and the first line after a field sync is line 1. A line sync that arrives in the same cycle as a field sync does not start a line.
- R3: The measurement uses only the line whose number equals `meas_line_i`. Luma on any other line has no effect on the class.
- R4: The measurement window is the SAMPLES luma samples that begin in the cycle after the measurement line's sync. The noise estimate is the sum of the absolute differences between consecutive samples inside the window, which gives SAMPLES-1 terms. Samples after the window are ignored.
- R5: An estimate greater than `thr_high_i` gives class 0. Otherwise, an estimate less than `thr_low_i` gives class 2. Every other estimate gives class 1, including estimates equal to either limit.
- R6: `class_o` changes only on the clock edge that registers the line sync starting line 1. At all other times it holds its value.
- R7: If no measurement has completed since the previous line-1 update, the next line-1 update leaves `class_o` unchanged.
- R8: If `vcr_i` is high at a line-1 update, `class_o` becomes 1 whatever the measurement was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| luma_i | input | DATA_W | Luminance sample |
| line_sync_i | input | 1 | One-cycle pulse at the start of each line |
| field_sync_i | input | 1 | One-cycle pulse at the start of each field |
| thr_low_i | input | SUM_W | Lower limit: an estimate below it means a clean signal |
| thr_high_i | input | SUM_W | Upper limit: an estimate above it means a noisy signal |
| vcr_i | input | 1 | Tape-source mode, which forces the middle class |
| meas_line_i | input | LINE_W | Number of the line to measure |
| class_o | output | 2 | Quality class |

## Verification
The bench sweeps the step size of the measurement-line pattern so that the estimate crosses both limits and lands exactly on each of them. A design that used strict and non-strict comparisons the wrong way round would report the wrong class at those two points. The non-measured lines and the samples after the window carry maximum swing, so a design that measured the wrong line, counted the line number off by one, or ran a window that was too long would report a noisy class for a clean line. At each field start the bench checks that the old class is still present before line 1 and that the new class appears exactly at line 1. It also covers fields with no measurement and fields with the tape bit set, which catch designs that reuse a stale result or ignore the override.

// File: rtl/snr_cls_pkg.sv
package snr_cls_pkg;
  typedef enum logic [1:0] {
    CLS_LOW  = 2'd0,
    CLS_MID  = 2'd1,
    CLS_HIGH = 2'd2
  } snr_cls_e;
endpackage

// File: rtl/snr_line_ctr.sv
module snr_line_ctr #(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_sync_i,
  input  logic              field_sync_i,
  output logic              line_start_o,
  output logic [LINE_W-1:0] next_line_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] line_q;

  assign line_start_o = line_sync_i && !field_sync_i;
  assign next_line_o  = (line_q == LINE_MAX) ? LINE_MAX : line_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           line_q <= '0;
    else if (field_sync_i) line_q <= '0;
    else if (line_sync_i)  line_q <= next_line_o;
  end

  p_field_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_sync_i |=> (line_q == '0));
  p_line_advances_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && line_q != LINE_MAX) |=> (line_q == $past(line_q) + 1'b1));
endmodule

// File: rtl/snr_noise_acc.sv
module snr_noise_acc #(
  parameter int DATA_W  = 8,
  parameter int SAMPLES = 256,
  parameter int SUM_W   = DATA_W + $clog2(SAMPLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] luma_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(SAMPLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] prev_q;
  logic [SUM_W-1:0]  acc_q;
  logic              done_q;
  logic [DATA_W-1:0] diff;

  assign diff   = (luma_i > prev_q) ? luma_i - prev_q : prev_q - luma_i;
  assign sum_o  = acc_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      prev_q   <= '0;
      acc_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i || abort_i) begin
        active_q <= start_i;
        cnt_q    <= '0;
        acc_q    <= '0;
      end else if (active_q) begin
        prev_q <= luma_i;
        cnt_q  <= cnt_q + 1'b1;
        // first sample only seeds the neighbour register
        if (cnt_q != '0) acc_q <= acc_q + SUM_W'(diff);
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  p_done_after_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(active_q) && !active_q));
  p_start_arms_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_q && cnt_q == '0 && acc_q == '0));
endmodule

// File: rtl/snr_cls_decide.sv
module snr_cls_decide
  import snr_cls_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SUM_W-1:0] sum_i,
  input  logic             done_i,
  input  logic [SUM_W-1:0] thr_low_i,
  input  logic [SUM_W-1:0] thr_high_i,
  input  logic             vcr_i,
  input  logic             update_i,
  output snr_cls_e         class_o
);
  snr_cls_e pend_q, class_q, meas_cls;
  logic     pend_v_q;

  always_comb begin
    if (sum_i > thr_high_i)     meas_cls = CLS_LOW;
    else if (sum_i < thr_low_i) meas_cls = CLS_HIGH;
    else                        meas_cls = CLS_MID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= CLS_MID;
      pend_v_q <= 1'b0;
      class_q  <= CLS_MID;
    end else begin
      if (update_i) begin
        if (vcr_i)         class_q <= CLS_MID;
        else if (pend_v_q) class_q <= pend_q;
      end
      if (done_i) begin
        pend_q   <= meas_cls;
        pend_v_q <= 1'b1;
      end else if (update_i) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign class_o = class_q;

  p_class_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o != 2'd3);
  p_hold_in_field_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(class_o));
  p_no_meas_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !vcr_i && !pend_v_q) |=> $stable(class_o));
  p_vcr_mid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && vcr_i) |=> (class_o == CLS_MID));
endmodule

// File: rtl/snr_line_classifier.sv
module snr_line_classifier
  import snr_cls_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SAMPLES = 256,
  parameter int LINE_W  = 10,
  parameter int SUM_W   = DATA_W + $clog2(SAMPLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] luma_i,
  input  logic              line_sync_i,
  input  logic              field_sync_i,
  input  logic [SUM_W-1:0]  thr_low_i,
  input  logic [SUM_W-1:0]  thr_high_i,
  input  logic              vcr_i,
  input  logic [LINE_W-1:0] meas_line_i,
  output logic [1:0]        class_o
);
  logic              line_start;
  logic [LINE_W-1:0] next_line;
  logic              meas_start, meas_abort, meas_done, first_line;
  logic [SUM_W-1:0]  meas_sum;
  snr_cls_e          cls;

  snr_line_ctr #(.LINE_W(LINE_W)) u_line_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_sync_i  (line_sync_i),
    .field_sync_i (field_sync_i),
    .line_start_o (line_start),
    .next_line_o  (next_line)
  );

  assign meas_start = line_start && (next_line == meas_line_i);
  assign meas_abort = line_sync_i || field_sync_i;
  assign first_line = line_start && (next_line == LINE_W'(1));

  snr_noise_acc #(.DATA_W(DATA_W), .SAMPLES(SAMPLES), .SUM_W(SUM_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (meas_start),
    .abort_i (meas_abort),
    .luma_i  (luma_i),
    .sum_o   (meas_sum),
    .done_o  (meas_done)
  );

  snr_cls_decide #(.SUM_W(SUM_W)) u_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sum_i      (meas_sum),
    .done_i     (meas_done),
    .thr_low_i  (thr_low_i),
    .thr_high_i (thr_high_i),
    .vcr_i      (vcr_i),
    .update_i   (first_line),
    .class_o    (cls)
  );

  assign class_o = cls;
endmodule

// File: tb/snr_line_classifier_tb_top.sv
module snr_line_classifier_tb_top;
  localparam int DATA_W  = 8;
  localparam int SAMPLES = 16;
  localparam int LINE_W  = 6;
  localparam int SUM_W   = DATA_W + $clog2(SAMPLES);
  localparam int LINES   = 6;
  localparam int PIX     = SAMPLES + 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] luma = '0;
  logic              ls = 1'b0, fs = 1'b0, vcr = 1'b0;
  logic [SUM_W-1:0]  thr_lo = '0, thr_hi = '0;
  logic [LINE_W-1:0] meas = '0;
  logic [1:0]        cls;

  int errors = 0, checks = 0;
  int cur = 1, pend = 1;
  bit pend_v = 0;

  always #5 clk = ~clk;

  snr_line_classifier #(.DATA_W(DATA_W), .SAMPLES(SAMPLES), .LINE_W(LINE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .luma_i(luma), .line_sync_i(ls), .field_sync_i(fs),
    .thr_low_i(thr_lo), .thr_high_i(thr_hi), .vcr_i(vcr), .meas_line_i(meas), .class_o(cls)
  );

  task automatic check(input int exp, input string tag);
    checks++;
    if (int'(cls) != exp) begin
      errors++;
      $display("FAIL %s: class actual=%0d expected=%0d", tag, cls, exp);
    end
  endtask

  function automatic int classify(input int s);
    if (s > int'(thr_hi)) return 0;
    if (s < int'(thr_lo)) return 2;
    return 1;
  endfunction

  // measured line: alternating 0/step inside the window; everything else swings 0/255
  task automatic run_field(input int step, input string tag);
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    check(cur, "R6 hold before line 1");
    for (int ln = 1; ln <= LINES; ln++) begin
      ls = 1'b1; luma = '0;
      @(negedge clk);
      ls = 1'b0;
      if (ln == 1) begin
        if (vcr) cur = 1;
        else if (pend_v) cur = pend;
        pend_v = 0;
        check(cur, tag);
      end
      for (int k = 0; k < PIX; k++) begin
        if (ln == int'(meas) && k < SAMPLES) luma = DATA_W'((k % 2) * step);
        else luma = DATA_W'((k % 2) * 255);
        @(negedge clk);
        if (k == PIX / 2) check(cur, "R6 hold mid field");
      end
    end
    if (int'(meas) >= 1 && int'(meas) <= LINES) begin
      pend = classify((SAMPLES - 1) * step);
      pend_v = 1;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    thr_lo = SUM_W'(45);
    thr_hi = SUM_W'(150);
    meas   = LINE_W'(4);
    repeat (3) @(negedge clk);
    check(1, "R1 reset class");
    rst_n = 1'b1;
    @(negedge clk);
    check(1, "R1 after reset");
    run_field(0, "R7 no prior measurement");
    // steps 3 and 10 land exactly on the limits
    for (int st = 0; st <= 17; st++) run_field(st, "R4/R5 step sweep");
    meas = LINE_W'(2);
    run_field(12, "R4/R5 last sweep point");
    run_field(0, "R2/R3 line 2 noisy");
    meas = LINE_W'(LINES);
    run_field(12, "R2/R3 line 2 clean");
    meas = LINE_W'(1);
    run_field(0, "R2/R3 last line noisy");
    meas = LINE_W'(4);
    run_field(5, "R3 line 1 clean");
    vcr = 1'b1;
    run_field(12, "R5 middle");
    run_field(0, "R8 tape mode forces middle");
    vcr = 1'b0;
    run_field(12, "R8 release uses clean result");
    meas = LINE_W'(9);
    run_field(0, "R5 noisy result");
    run_field(0, "R7 no measurement holds");
    meas = LINE_W'(4);
    run_field(0, "R7 still held");
    run_field(0, "R4 window tail ignored");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule